// File: doc/BRIEF.md
# Carry-less multiply execution unit

This functional unit sits beside an integer pipeline and evaluates the three carry-less (GF(2) polynomial) multiply instructions of a RISC-V style ISA. It receives the 32-bit instruction word and the two source operand values already read from the register file. It recognises the carry-less multiply encodings and returns one XLEN-wide slice of the 2·XLEN-bit polynomial product, all in the same cycle.

Two enable inputs say which of the two extensions that carry these instructions are active: the bit-manipulation carry-less set and the cryptography carry-less set. The unit flags a recognised but unusable encoding as illegal, so the surrounding pipeline can raise its own exception. Register file access, hazards, writeback and traps stay outside the unit.

Top module: `clmul_unit`

## Requirements
- R1: An instruction is recognised only when bits [31:25] equal 7'b0000101 and bits [6:0] equal 7'b0110011. Otherwise `valid`, `illegal` and `result` are all zero.
- R2: With funct3 (bits [14:12]) equal to 3'b001, `result` is the low half of the carry-less product: the XOR, over each set bit i of `src_b`, of `src_a << i`, truncated to XLEN bits.
- R3: With funct3 equal to 3'b011, `result` is the high half: the XOR, over each set bit i of `src_b` with i ≥ 1, of `src_a >> (XLEN - i)`. Bit 0 of `src_b` contributes nothing, so the most significant result bit is always zero.
- R4: With funct3 equal to 3'b010, `result` is the reversed slice: the XOR, over each set bit i of `src_b`, of `src_a >> (XLEN - 1 - i)`. This equals product bits [2·XLEN-2:XLEN-1].
- R5: Low-half and high-half forms are legal when `bitmanip_en` or `crypto_en` is high. The reversed form is legal only when `bitmanip_en` is high.
- R6: A recognised instruction whose funct3 is not one of the three values, or whose form is not legal under R5, drives `illegal` high, `valid` low and `result` zero.
- R7: `valid` is high exactly for a recognised, legal form. `valid` and `illegal` are never both high, and every output follows the inputs without a clock.
- R8: The bits [24:20], [19:15] and [11:7] (register indices) have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word under decode |
| src_a | input | XLEN | First source operand (multiplicand) |
| src_b | input | XLEN | Second source operand (bits scanned as multiplier) |
| bitmanip_en | input | 1 | Bit-manipulation carry-less extension is active |
| crypto_en | input | 1 | Cryptography carry-less extension is active |
| result | output | XLEN | Selected product slice, zero unless valid |
| valid | output | 1 | Legal carry-less multiply decoded |
| illegal | output | 1 | Carry-less encoding recognised but not usable |

## Verification
The embedded checks evaluate the outputs whenever any input changes, so they assume settled, two-state values on `instr` and both operands, with no X or Z bits. The bench drives every input from a known value on the falling clock edge and samples after settling. Its random stimulus draws funct3 from the three legal codes plus unused codes, and sometimes corrupts funct7 or the opcode, so decode cases outside the three forms occur and are checked. Operand values include full-width random patterns, zero, all-ones and single bits at either end.

// File: rtl/clmul_unit.sv
module clmul_unit #(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic            bitmanip_en,
  input  logic            crypto_en,
  output logic [XLEN-1:0] result,
  output logic            valid,
  output logic            illegal
);
  localparam logic [6:0] FN7_CLM = 7'b0000101;
  localparam logic [6:0] OPC_REG = 7'b0110011;
  localparam logic [2:0] FN3_LO  = 3'b001;
  localparam logic [2:0] FN3_REV = 3'b010;
  localparam logic [2:0] FN3_HI  = 3'b011;

  logic            hit, sel_lo, sel_hi, sel_rev, lo_ok, rev_ok;
  logic [XLEN-1:0] part_lo [XLEN];
  logic [XLEN-1:0] part_hi [XLEN];
  logic [XLEN-1:0] part_rv [XLEN];
  logic [XLEN-1:0] prod_lo, prod_hi, prod_rv;

  assign hit     = (instr[31:25] == FN7_CLM) && (instr[6:0] == OPC_REG);
  assign sel_lo  = hit && (instr[14:12] == FN3_LO);
  assign sel_hi  = hit && (instr[14:12] == FN3_HI);
  assign sel_rev = hit && (instr[14:12] == FN3_REV);
  assign lo_ok   = bitmanip_en | crypto_en;
  assign rev_ok  = bitmanip_en;

  for (genvar i = 0; i < XLEN; i++) begin : g_part
    assign part_lo[i] = src_b[i] ? (src_a << i) : '0;
    assign part_rv[i] = src_b[i] ? (src_a >> (XLEN - 1 - i)) : '0;
    if (i == 0) begin : g_hi_zero
      assign part_hi[i] = '0;
    end else begin : g_hi_shift
      assign part_hi[i] = src_b[i] ? (src_a >> (XLEN - i)) : '0;
    end
  end

  always_comb begin
    prod_lo = '0;
    prod_hi = '0;
    prod_rv = '0;
    for (int k = 0; k < XLEN; k++) begin
      prod_lo = prod_lo ^ part_lo[k];
      prod_hi = prod_hi ^ part_hi[k];
      prod_rv = prod_rv ^ part_rv[k];
    end
  end

  assign valid   = ((sel_lo || sel_hi) && lo_ok) || (sel_rev && rev_ok);
  assign illegal = hit && !valid;
  assign result  = !valid ? '0 : sel_rev ? prod_rv : sel_hi ? prod_hi : prod_lo;

  always_comb begin
    assert_no_decode_R1: assert (hit || (!valid && !illegal && result == '0))
      else $error("unrecognised word produced output");
    assert_hi_msb_zero_R3: assert (prod_hi[XLEN-1] == 1'b0)
      else $error("high half top bit set");
    assert_rev_align_R4: assert (prod_rv == {prod_hi[XLEN-2:0], prod_lo[XLEN-1]})
      else $error("reversed slice misaligned with low/high halves");
    assert_rev_gate_R5: assert (!(valid && sel_rev) || bitmanip_en)
      else $error("reversed form accepted without its extension");
    assert_illegal_zero_R6: assert (!illegal || result == '0)
      else $error("illegal decode drove a result");
    assert_excl_R7: assert (!(valid && illegal))
      else $error("valid and illegal together");
  end
endmodule

// File: tb/clmul_unit_test.sv
module clmul_unit_test;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic [31:0]     instr = '0;
  logic [XLEN-1:0] src_a = '0, src_b = '0;
  logic            bitmanip_en = 1'b0, crypto_en = 1'b0;
  logic [XLEN-1:0] result;
  logic            valid, illegal;
  int              total = 0, fails = 0;

  always #2 clk = ~clk;

  clmul_unit #(.XLEN(XLEN)) uut (
    .instr(instr), .src_a(src_a), .src_b(src_b),
    .bitmanip_en(bitmanip_en), .crypto_en(crypto_en),
    .result(result), .valid(valid), .illegal(illegal)
  );

  function automatic logic [2*XLEN-1:0] full_prod(logic [XLEN-1:0] a, logic [XLEN-1:0] b);
    logic [2*XLEN-1:0] acc = '0;
    for (int i = 0; i < XLEN; i++)
      if (b[i]) acc = acc ^ ({{XLEN{1'b0}}, a} << i);
    return acc;
  endfunction

  function automatic logic [31:0] mk(logic [6:0] f7, logic [4:0] r2, logic [4:0] r1,
                                     logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {f7, r2, r1, f3, rd, op};
  endfunction

  task automatic check(string req, string what, logic [XLEN-1:0] got, logic [XLEN-1:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic apply(logic [31:0] w, logic [XLEN-1:0] a, logic [XLEN-1:0] b, logic bm, logic cr);
    logic [2*XLEN-1:0] p;
    logic              hit, leg, e_valid;
    logic [XLEN-1:0]   e_res;
    string             tag;
    @(negedge clk);
    instr = w; src_a = a; src_b = b; bitmanip_en = bm; crypto_en = cr;
    #1;
    p   = full_prod(a, b);
    hit = (w[31:25] == 7'b0000101) && (w[6:0] == 7'b0110011);
    leg = 1'b0; e_res = '0; tag = "R1";
    if (hit) begin
      tag = "R6";
      case (w[14:12])
        3'b001: begin leg = bm | cr; e_res = p[XLEN-1:0];        tag = leg ? "R2" : "R5"; end
        3'b011: begin leg = bm | cr; e_res = p[2*XLEN-1:XLEN];   tag = leg ? "R3" : "R5"; end
        3'b010: begin leg = bm;      e_res = p[2*XLEN-2:XLEN-1]; tag = leg ? "R4" : "R5"; end
        default: leg = 1'b0;
      endcase
    end
    e_valid = hit && leg;
    if (!e_valid) e_res = '0;
    check(tag, "result", result, e_res);
    check("R7", "valid", XLEN'(valid), XLEN'(e_valid));
    check(hit && !leg ? "R6" : "R7", "illegal", XLEN'(illegal), XLEN'(hit && !leg));
  endtask

  initial begin
    #800000;
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [XLEN-1:0] a, b, r_ref;
    logic [31:0]     w;
    logic [2:0]      f3;
    void'($urandom(32'd1234));
    #1;
    check("R1", "idle result", result, '0);
    check("R1", "idle valid", XLEN'(valid), '0);
    check("R1", "idle illegal", XLEN'(illegal), '0);

    // R2 R3 R4 directed corners
    for (int f = 1; f <= 3; f++) begin
      w = mk(7'b0000101, 5'd3, 5'd4, 3'(f), 5'd5, 7'b0110011);
      apply(w, '0, '0, 1'b1, 1'b0);
      apply(w, '1, '1, 1'b1, 1'b0);
      apply(w, '1, XLEN'(1), 1'b1, 1'b1);
      apply(w, XLEN'(1), '1, 1'b1, 1'b0);
      apply(w, {1'b1, {(XLEN-1){1'b0}}}, {1'b1, {(XLEN-1){1'b0}}}, 1'b1, 1'b0);
      apply(w, XLEN'(1), {1'b1, {(XLEN-1){1'b0}}}, 1'b1, 1'b0);
      apply(w, 32'hdeadbeef, '0, 1'b1, 1'b0);
    end
    // R3: only bit 0 of src_b set gives zero high half
    apply(mk(7'b0000101, 0, 0, 3'b011, 0, 7'b0110011), '1, XLEN'(1), 1'b0, 1'b1);
    check("R3", "bit0 high half", result, '0);

    // R5 gating
    for (int f = 1; f <= 3; f++)
      for (int e = 0; e < 4; e++)
        apply(mk(7'b0000101, 1, 2, 3'(f), 3, 7'b0110011), 32'h13572468, 32'h8000_0101, e[0], e[1]);

    // R6 unused funct3 values and R1 near-miss encodings
    for (int f = 4; f < 8; f++)
      apply(mk(7'b0000101, 1, 2, 3'(f), 3, 7'b0110011), '1, '1, 1'b1, 1'b1);
    apply(mk(7'b0000101, 1, 2, 3'b000, 3, 7'b0110011), '1, '1, 1'b1, 1'b1);
    apply(mk(7'b0000100, 1, 2, 3'b001, 3, 7'b0110011), '1, '1, 1'b1, 1'b1);
    apply(mk(7'b0000101, 1, 2, 3'b001, 3, 7'b0110111), '1, '1, 1'b1, 1'b1);

    // R8 register index fields have no effect
    a = 32'hcafe1234; b = 32'h0f0f_a5a5;
    r_ref = full_prod(a, b) >> (XLEN - 1);
    for (int k = 0; k < 8; k++) begin
      apply(mk(7'b0000101, 5'($urandom), 5'($urandom), 3'b010, 5'($urandom), 7'b0110011), a, b, 1'b1, 1'b0);
      check("R8", "index independence", result, r_ref);
    end

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      case ($urandom % 6)
        0, 1:    f3 = 3'b001;
        2:       f3 = 3'b011;
        3:       f3 = 3'b010;
        default: f3 = 3'($urandom);
      endcase
      w = mk(($urandom % 8 == 0) ? 7'($urandom) : 7'b0000101, 5'($urandom), 5'($urandom), f3,
             5'($urandom), ($urandom % 8 == 0) ? 7'($urandom) : 7'b0110011);
      apply(w, XLEN'($urandom), XLEN'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule